// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave-side serial front end of a small byte-addressed EEPROM with 512 locations. It watches a four-wire serial link made up of chip select (active low), serial clock, serial data in and serial data out. It oversamples all of these with the system clock. After every falling edge of chip select it collects an 8-bit command. For array accesses the top address bit travels inside the command, and the low eight address bits follow in the next byte.

Reads return data from an internal byte array. While chip select stays low, reads keep streaming from consecutive addresses and wrap from the last location back to the first. A single-byte write is placed in the array when chip select closes the frame. It is committed only if the external status unit reports that the target address is writable.

The commands that set and clear write permission, and the command that loads the protection field, are not executed here. They are handed to that status unit as one-cycle requests. The status-read command streams the byte the status unit presents.

Top module: `spi_eeprom_cmd`

## Requirements
- R1: The link runs in clock mode 0. Every byte is shifted most significant bit first. SI is captured on rising SCK, and SO changes only after falling SCK.
- R2: `so_oe` is 0 after reset and is 0 whenever chip select is high. It is 1 only while a read or status-read is returning data.
- R3: The command byte is decoded on its eighth bit and needs an upper nibble of 0000. The low three bits select the command: 110 set-permission, 100 clear-permission, 101 status read, 001 status write, 011 array read, 010 array write. Bit 3 is a don't-care for the first four commands.
- R4: An array read (0000_A011) takes address bit 8 from bit 3 of the command and bits 7..0 from the next byte. From then on SI is ignored. Data appears on SO starting at the falling SCK edge that follows the last address bit.
- R5: While chip select stays low, a read continues at the next address after every 8 output bits. It wraps from 0x1FF to 0x000, and it carries from 0x0FF into 0x100.
- R6: An array write (0000_A010, then an address byte, then a data byte) stores the data when chip select rises after exactly 24 bits, provided `wr_allow` is 1 in that cycle. `wr_addr` shows the target address while the status unit decides.
- R7: A write with `wr_allow` at 0 leaves the array unchanged.
- R8: A set-permission or clear-permission command produces one `st_req` pulse, with `st_op` 00 or 01 respectively. The pulse comes on the chip-select rise, and only if exactly 8 bits were shifted.
- R9: A status write (0000_x001, then a data byte) produces one `st_req` pulse on the chip-select rise after exactly 16 bits. It carries `st_op` 10, and `st_wdata` holds the data byte.
- R10: A status read (0000_x101) shifts out `st_rdata`, sampled again at the start of each byte, for as long as chip select stays low.
- R11: An unrecognised command byte has no effect for the rest of the frame: no request, no write, and no SO drive.
- R12: A chip-select rise mid-byte, or at any bit count other than the one the command needs, discards the frame. A later frame decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for `so` (0 means high impedance) |
| st_req | output | 1 | One-cycle request to the status unit |
| st_op | output | 2 | Request code: 00 set-permission, 01 clear-permission, 10 status write |
| st_wdata | output | 8 | Data byte for a status write |
| st_rdata | input | 8 | Status byte returned by a status read |
| wr_addr | output | ADDR_W | Address of the pending or current access |
| wr_allow | input | 1 | Status unit's verdict that `wr_addr` may be written |

## Verification
The bench uses the default parameters: a 9-bit address (512 bytes) and a two-stage input synchroniser, with SCK held for eight system clocks per phase. With the full 512-byte array built, the wrap from 0x1FF to 0x000 can be reached by a streamed read. So can the carry from 0x0FF into the address bit that rides in the command byte. Both are checked against bytes written through the same link. A bench model of the status unit drives `wr_allow` from its permission latch and its protection field. This lets protected writes, writes without permission, and bit-count boundaries be told apart at SO.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RXDATA,
        ST_TX,
        ST_ARMED,
        ST_DROP
    } eng_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WREN,
        OP_WRDI,
        OP_RDSR,
        OP_WRSR,
        OP_READ,
        OP_WRITE
    } op_e;

    localparam logic [1:0] REQ_SET_WE = 2'b00;
    localparam logic [1:0] REQ_CLR_WE = 2'b01;
    localparam logic [1:0] REQ_STATUS = 2'b10;

    // Command decode: upper nibble must be zero, bit 3 is handled by the caller
    function automatic op_e decode_op(input logic [7:0] cmd);
        op_e res;
        res = OP_NONE;
        if (cmd[7:4] == 4'h0) begin
            case (cmd[2:0])
                3'b110:  res = OP_WREN;
                3'b100:  res = OP_WRDI;
                3'b101:  res = OP_RDSR;
                3'b001:  res = OP_WRSR;
                3'b011:  res = OP_READ;
                3'b010:  res = OP_WRITE;
                default: res = OP_NONE;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/spi_ee_edge.sv
module spi_ee_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic cs_lvl,
    output logic cs_rise,
    output logic cs_fall,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_lvl
);

    localparam int S = SYNC_STAGES;

    typedef struct packed {
        logic [S-1:0] cs;
        logic [S-1:0] ck;
        logic [S-1:0] dat;
        logic         cs_prev;
        logic         ck_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d         = sync_q;
        sync_d.cs      = S'({sync_q.cs, cs_n});
        sync_d.ck      = S'({sync_q.ck, sck});
        sync_d.dat     = S'({sync_q.dat, si});
        sync_d.cs_prev = sync_q.cs[S-1];
        sync_d.ck_prev = sync_q.ck[S-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.cs      <= '1;
            sync_q.ck      <= '0;
            sync_q.dat     <= '0;
            sync_q.cs_prev <= 1'b1;
            sync_q.ck_prev <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign cs_lvl   = sync_q.cs[S-1];
    assign cs_rise  =  sync_q.cs[S-1] & ~sync_q.cs_prev;
    assign cs_fall  = ~sync_q.cs[S-1] &  sync_q.cs_prev;
    assign sck_rise =  sync_q.ck[S-1] & ~sync_q.ck_prev;
    assign sck_fall = ~sync_q.ck[S-1] &  sync_q.ck_prev;
    assign si_lvl   = sync_q.dat[S-1];

    // R12: a select edge is reported for one cycle only
    p_cs_edge_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !cs_rise);

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = cells[raddr];
    end

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/spi_ee_engine.sv
module spi_ee_engine
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              si_lvl,
    input  logic [7:0]        st_rdata,
    input  logic              wr_allow,
    input  logic [7:0]        mem_rdata,
    output logic              so,
    output logic              so_oe,
    output logic              st_req,
    output logic [1:0]        st_op,
    output logic [7:0]        st_wdata,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr
);

    typedef struct packed {
        eng_state_e        state;
        op_e               op;
        logic [7:0]        rx;
        logic [2:0]        bitc;
        logic              a8;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        tx;
        logic [2:0]        txc;
        logic              so;
        logic              load;
        logic              st_req;
        logic [1:0]        st_op;
        logic [7:0]        st_wdata;
    } eng_t;

    eng_t       e_d, e_q;
    logic [7:0] rx_next;
    logic       byte_done;
    logic       rd_req;
    logic       wr_req;

    always_comb begin
        e_d        = e_q;
        e_d.st_req = 1'b0;
        e_d.load   = 1'b0;
        rd_req     = 1'b0;
        wr_req     = 1'b0;
        rx_next    = {e_q.rx[6:0], si_lvl};
        byte_done  = (e_q.bitc == 3'd7);

        // Array data requested in the previous cycle arrives now
        if (e_q.load) e_d.tx = mem_rdata;

        if (cs_rise) begin
            if (e_q.state == ST_ARMED) begin
                case (e_q.op)
                    OP_WREN: begin
                        e_d.st_req = 1'b1;
                        e_d.st_op  = REQ_SET_WE;
                    end
                    OP_WRDI: begin
                        e_d.st_req = 1'b1;
                        e_d.st_op  = REQ_CLR_WE;
                    end
                    OP_WRSR: begin
                        e_d.st_req   = 1'b1;
                        e_d.st_op    = REQ_STATUS;
                        e_d.st_wdata = e_q.rx;
                    end
                    OP_WRITE: wr_req = wr_allow;
                    default: ;
                endcase
            end
            e_d.state = ST_IDLE;
        end else if (cs_lvl) begin
            e_d.state = ST_IDLE;
        end else if (cs_fall) begin
            e_d.state = ST_OPC;
            e_d.op    = OP_NONE;
            e_d.bitc  = 3'd0;
            e_d.txc   = 3'd0;
            e_d.rx    = 8'h00;
            e_d.so    = 1'b0;
        end else begin
            if (sck_rise) begin
                case (e_q.state)
                    ST_OPC: begin
                        e_d.rx   = rx_next;
                        e_d.bitc = e_q.bitc + 3'd1;
                        if (byte_done) begin
                            e_d.op = decode_op(rx_next);
                            e_d.a8 = rx_next[3];
                            case (decode_op(rx_next))
                                OP_WREN, OP_WRDI: e_d.state = ST_ARMED;
                                OP_RDSR: begin
                                    e_d.state = ST_TX;
                                    e_d.tx    = st_rdata;
                                end
                                OP_WRSR:           e_d.state = ST_RXDATA;
                                OP_READ, OP_WRITE: e_d.state = ST_ADDR;
                                default:           e_d.state = ST_DROP;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        e_d.rx   = rx_next;
                        e_d.bitc = e_q.bitc + 3'd1;
                        if (byte_done) begin
                            e_d.addr = ADDR_W'({e_q.a8, rx_next});
                            if (e_q.op == OP_READ) begin
                                e_d.state = ST_TX;
                                rd_req    = 1'b1;
                                e_d.load  = 1'b1;
                            end else begin
                                e_d.state = ST_RXDATA;
                            end
                        end
                    end
                    ST_RXDATA: begin
                        e_d.rx   = rx_next;
                        e_d.bitc = e_q.bitc + 3'd1;
                        if (byte_done) e_d.state = ST_ARMED;
                    end
                    ST_ARMED: e_d.state = ST_DROP;
                    default: ;
                endcase
            end
            if (sck_fall && e_q.state == ST_TX) begin
                e_d.so  = e_q.tx[7];
                e_d.tx  = {e_q.tx[6:0], 1'b0};
                e_d.txc = e_q.txc + 3'd1;
                if (e_q.txc == 3'd7) begin
                    if (e_q.op == OP_READ) begin
                        e_d.addr = e_q.addr + 1'b1;
                        rd_req   = 1'b1;
                        e_d.load = 1'b1;
                    end else begin
                        e_d.tx = st_rdata;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.state    <= ST_IDLE;
            e_q.op       <= OP_NONE;
            e_q.rx       <= '0;
            e_q.bitc     <= '0;
            e_q.a8       <= 1'b0;
            e_q.addr     <= '0;
            e_q.tx       <= '0;
            e_q.txc      <= '0;
            e_q.so       <= 1'b0;
            e_q.load     <= 1'b0;
            e_q.st_req   <= 1'b0;
            e_q.st_op    <= '0;
            e_q.st_wdata <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign so        = e_q.so;
    assign so_oe     = (e_q.state == ST_TX);
    assign st_req    = e_q.st_req;
    assign st_op     = e_q.st_op;
    assign st_wdata  = e_q.st_wdata;
    assign acc_addr  = e_q.addr;
    assign mem_we    = wr_req;
    assign mem_wdata = e_q.rx;
    assign mem_re    = rd_req;
    assign mem_raddr = e_d.addr;

    // R2: no drive on SO once deselect has been seen
    p_quiet_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> !so_oe);

    // R1: SO holds its value except after a falling SCK
    p_so_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state == ST_TX && !sck_fall && !cs_fall) |=> $stable(e_q.so));

    // R4: data in is ignored while streaming out
    p_si_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state == ST_TX && sck_rise && !cs_lvl) |=> $stable(e_q.rx));

    // R5: each new byte of a stream comes from the next address
    p_stream_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && e_q.state == ST_TX) |=> (e_q.addr == $past(e_q.addr) + 1'b1));

    // R7: the array is written only with permission at a frame close
    p_write_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wr_allow && cs_rise));

    // R8: status requests are raised only by a frame close
    p_req_on_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> $past(cs_rise));

endmodule

// File: rtl/spi_eeprom_cmd.sv
module spi_eeprom_cmd #(
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    output logic              st_req,
    output logic [1:0]        st_op,
    output logic [7:0]        st_wdata,
    input  logic [7:0]        st_rdata,
    output logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_allow
);

    logic              cs_lvl, cs_rise, cs_fall, sck_rise, sck_fall, si_lvl;
    logic              mem_we, mem_re;
    logic [7:0]        mem_wdata, mem_rdata;
    logic [ADDR_W-1:0] acc_addr, mem_raddr;

    spi_ee_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .si       (si),
        .cs_lvl   (cs_lvl),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_lvl   (si_lvl)
    );

    spi_ee_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lvl    (cs_lvl),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .si_lvl    (si_lvl),
        .st_rdata  (st_rdata),
        .wr_allow  (wr_allow),
        .mem_rdata (mem_rdata),
        .so        (so),
        .so_oe     (so_oe),
        .st_req    (st_req),
        .st_op     (st_op),
        .st_wdata  (st_wdata),
        .acc_addr  (acc_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .mem_raddr (mem_raddr)
    );

    spi_ee_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (acc_addr),
        .wdata (mem_wdata),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign wr_addr = acc_addr;

endmodule

// File: tb/spi_eeprom_cmd_bench.sv
module spi_eeprom_cmd_bench;

    localparam int AW = 9;
    localparam int HP = 8;
    localparam int NV = 10;

    // {address, data}
    localparam logic [16:0] VEC [NV] = '{
        {9'h000, 8'h3C}, {9'h001, 8'h81}, {9'h0FF, 8'h7E}, {9'h100, 8'hC3},
        {9'h17F, 8'h11}, {9'h180, 8'h22}, {9'h1FE, 8'h96}, {9'h1FF, 8'h69},
        {9'h055, 8'hAA}, {9'h0AA, 8'h55}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic          so, so_oe, st_req, wr_allow;
    logic [1:0]    st_op;
    logic [7:0]    st_wdata, st_rdata;
    logic [AW-1:0] wr_addr;

    always #2 clk = ~clk;

    spi_eeprom_cmd u_spi_eeprom_cmd (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .st_req(st_req), .st_op(st_op),
        .st_wdata(st_wdata), .st_rdata(st_rdata), .wr_addr(wr_addr),
        .wr_allow(wr_allow)
    );

    // Status unit model: permission latch and protection field
    logic       wen_m;
    logic [1:0] bp_m;
    int         req_cnt;
    logic [1:0] last_op;
    logic [7:0] last_wd;
    int         hi_cnt;
    logic       oe_leak;

    function automatic logic prot(input logic [AW-1:0] a, input logic [1:0] bp);
        case (bp)
            2'd1:    return a >= 9'h180;
            2'd2:    return a >= 9'h100;
            2'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    assign st_rdata = {4'h0, bp_m, wen_m, 1'b0};
    assign wr_allow = wen_m && !prot(wr_addr, bp_m);

    always @(posedge clk) begin
        if (!rst_n) begin
            wen_m <= 1'b0; bp_m <= 2'd0; req_cnt <= 0;
            last_op <= 2'd3; last_wd <= 8'h00;
        end else if (st_req) begin
            req_cnt <= req_cnt + 1;
            last_op <= st_op;
            last_wd <= st_wdata;
            case (st_op)
                2'b00: wen_m <= 1'b1;
                2'b01: wen_m <= 1'b0;
                2'b10: bp_m  <= st_wdata[3:2];
                default: ;
            endcase
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 0; oe_leak <= 1'b0;
        end else begin
            hi_cnt <= cs_n ? hi_cnt + 1 : 0;
            if (hi_cnt > 6 && so_oe) oe_leak <= 1'b1;
        end
    end

    int   n_run = 0, n_fail = 0;
    logic done = 1'b0;
    logic oe_any;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [31:0] pat, input int n, output logic [31:0] got);
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            si = pat[i];
            repeat (HP) @(negedge clk);
            got = {got[30:0], so};
            if (so_oe) oe_any = 1'b1;
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic open_frame();
        oe_any = 1'b0;
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic close_frame();
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HP) @(negedge clk);
    endtask

    function automatic logic [7:0] op_rd(input logic [AW-1:0] a);
        return {4'h0, a[8], 3'b011};
    endfunction

    function automatic logic [7:0] op_wr(input logic [AW-1:0] a);
        return {4'h0, a[8], 3'b010};
    endfunction

    task automatic cmd_only(input logic [7:0] c, input int nbits);
        logic [31:0] g;
        open_frame();
        shift_bits({24'h0, c} << (nbits > 8 ? nbits - 8 : 0), nbits, g);
        close_frame();
    endtask

    task automatic write_bits(input logic [AW-1:0] a, input logic [7:0] d, input int nbits);
        logic [31:0] g, pat;
        pat = {8'h00, op_wr(a), a[7:0], d};
        open_frame();
        if (nbits <= 24) shift_bits(pat >> (24 - nbits), nbits, g);
        else             shift_bits(pat << (nbits - 24), nbits, g);
        close_frame();
    endtask

    task automatic read_first(input logic [AW-1:0] a, output logic [7:0] d);
        logic [31:0] g;
        open_frame();
        shift_bits({16'h0, op_rd(a), a[7:0]}, 16, g);
        shift_bits(32'hFF, 8, g);
        d = g[7:0];
    endtask

    task automatic read_next(output logic [7:0] d);
        logic [31:0] g;
        shift_bits(32'hFF, 8, g);
        d = g[7:0];
    endtask

    initial begin
        logic [7:0]  b;
        logic [31:0] g;
        int          rc;
        oe_any = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 so_oe in reset", {31'b0, so_oe}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 so_oe after reset", {31'b0, so_oe}, 0);
        chk("R8 no request after reset", req_cnt, 0);

        // R8: set-permission, 8 bits exactly
        cmd_only(8'h06, 8);
        chk("R8 set-permission count", req_cnt, 1);
        chk("R8 set-permission code", {30'b0, last_op}, 0);

        // R6: table of writes, then table of read-backs
        for (int i = 0; i < NV; i++)
            write_bits(VEC[i][16:8], VEC[i][7:0], 24);
        for (int i = 0; i < NV; i++) begin
            read_first(VEC[i][16:8], b);
            chk("R4 so driven during read", {31'b0, oe_any}, 1);
            close_frame();
            chk($sformatf("R6 R4 read-back @%0h", VEC[i][16:8]), b, VEC[i][7:0]);
        end

        // R5: stream across the top of the array
        read_first(9'h1FE, b); chk("R5 stream 1FE", b, 8'h96);
        read_next(b);          chk("R5 stream 1FF", b, 8'h69);
        read_next(b);          chk("R5 wrap to 000", b, 8'h3C);
        read_next(b);          chk("R5 stream 001", b, 8'h81);
        close_frame();
        read_first(9'h0FF, b); chk("R5 stream 0FF", b, 8'h7E);
        read_next(b);          chk("R5 carry to 100", b, 8'hC3);
        close_frame();

        // R10 / R3: status read with bit 3 set, two bytes
        open_frame();
        shift_bits(32'h0D, 8, g);
        shift_bits(32'hFF, 8, g); chk("R10 R3 status byte 0", g[7:0], 8'h02);
        shift_bits(32'hFF, 8, g); chk("R10 status byte 1", g[7:0], 8'h02);
        close_frame();

        // R9: status write sets protection of the top quarter
        rc = req_cnt;
        open_frame();
        shift_bits({16'h0, 8'h09, 8'h04}, 16, g);
        close_frame();
        chk("R9 status write count", req_cnt, rc + 1);
        chk("R9 status write code", {30'b0, last_op}, 2);
        chk("R9 status write data", last_wd, 8'h04);

        // R7: protected address keeps old data, open address takes new data
        write_bits(9'h1FF, 8'h5A, 24);
        read_first(9'h1FF, b); close_frame();
        chk("R7 protected write ignored", b, 8'h69);
        write_bits(9'h17F, 8'h5A, 24);
        read_first(9'h17F, b); close_frame();
        chk("R6 open write committed", b, 8'h5A);

        // R8 / R3: clear-permission with bit 3 set, then write is refused
        cmd_only(8'h0C, 8);
        chk("R8 R3 clear-permission code", {30'b0, last_op}, 1);
        write_bits(9'h000, 8'hEE, 24);
        read_first(9'h000, b); close_frame();
        chk("R7 write without permission", b, 8'h3C);

        // R8 boundary: 9 and 7 bits give no request
        rc = req_cnt;
        cmd_only(8'h06, 9);
        cmd_only(8'h06, 7);
        chk("R8 R12 wrong bit count", req_cnt, rc);

        // R11: unrecognised commands
        cmd_only(8'h16, 8);
        cmd_only(8'h07, 8);
        chk("R11 no request from bad opcode", req_cnt, rc);
        open_frame();
        shift_bits({16'h0, 8'h13, 8'h00}, 16, g);
        shift_bits(32'hFF, 8, g);
        close_frame();
        chk("R11 no SO drive on bad opcode", {31'b0, oe_any}, 0);

        // R12: partial frames discarded, full frame after them works
        cmd_only(8'h0E, 8);
        open_frame(); shift_bits({16'h0, 8'h01, 8'h00}, 16, g); close_frame();
        chk("R9 protection cleared", {30'b0, bp_m}, 0);
        write_bits(9'h000, 8'h4D, 20);
        read_first(9'h000, b); close_frame();
        chk("R12 20-bit write dropped", b, 8'h3C);
        write_bits(9'h000, 8'h4D, 25);
        read_first(9'h000, b); close_frame();
        chk("R12 25-bit write dropped", b, 8'h3C);
        open_frame(); shift_bits(32'h0, 4, g); close_frame();
        write_bits(9'h000, 8'h4D, 24);
        read_first(9'h000, b); close_frame();
        chk("R12 R6 frame after partial", b, 8'h4D);

        chk("R2 so_oe low while deselected", {31'b0, oe_leak}, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule